// File: doc/BRIEF.md
# Sensor Register Target on a Two-Wire Serial Bus

This block is the bus-facing front end of a small temperature-sensing macro. It watches an already-synchronized two-wire serial bus (clock and data), pulls the data line low through an open-drain enable, and exposes four 16-bit registers to a bus master. The four registers are: a read-only temperature word supplied by the conversion logic, an 8-bit configuration byte, and two 16-bit limit words. A pointer register set by the master selects among them.

The block answers its own 7-bit address, which it derives from two three-level strap pins. It also answers the general-call address, which can re-sample those pins and reset the registers. It takes part in the alert-response exchange, including arbitration against other targets on the bus, and it notes when a master announces high-speed signalling. Completed register reads and won alert arbitrations are reported to the neighbouring alert logic as single-cycle strobes.

Top module: `sens_i2c_target`

## Requirements
- R1: The device address is binary 1001 followed by three bits taken from pins B and A, each encoded 00 low, 01 high, 1x floating. The three bits for each (B, A) pair are as follows:
  - B low: A low 000, A floating 001, A high 010.
  - B high: A low 100, A floating 101, A high 110.
  - B floating: A low 011, A high 111, A floating 011.
  
  A byte whose upper seven bits equal the address is acknowledged.
- R2: The pins are sampled at the first START after reset and on a general-call latch or reset command. At all other times the address is held, even if the pins move.
- R3: In a write, the first byte after the address is the pointer. Its two low bits select 00 temperature, 01 configuration, 10 low limit, 11 high limit. The pointer resets to 00.
- R4: A read returns the register named by the last pointer written, high byte first and then low byte. Later reads with no new pointer return the same register. The temperature register returns the `tempIn` value.
- R5: Each data byte written is acknowledged. A write made of the pointer alone is legal and changes nothing else. For the limit registers, the first data byte is the high byte and the second is the low byte. Writes aimed at the temperature register change no register.
- R6: The configuration register takes only the first data byte of a write; later bytes leave it unchanged. Its bit 1 enables interrupt mode.
- R7: Address byte 0x00 (general call, write) is acknowledged. A second byte of 0x04 re-samples the pins. A second byte of 0x06 re-samples the pins and restores the reset values: pointer 00, configuration 0x00, low limit 0x4B00, high limit 0x5000.
- R8: Address byte 0x19 (alert response, read) is acknowledged only while `alertPending` is high and interrupt mode is set. The target then sends {address, `alertStatus`}. If the data line reads low in a bit the target leaves released, the target drops out. If the target completes the byte, `araWon` pulses once.
- R9: A first byte of the form 00001xxx is not acknowledged and sets `hsMode`. `hsMode` stays set through repeated STARTs and clears at the next STOP.
- R10: `rdStb` pulses once when the master's acknowledge bit after a low register byte is sampled. A read that the master ends with NACK after the high byte gives no pulse.
- R11: The target only ever pulls the data line low, and it never starts pulling while the clock is high.
- R12: An address byte that matches nothing is not acknowledged. The target then leaves the data line released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronized bus clock level |
| sdaIn | input | 1 | Synchronized bus data level |
| sdaOe | output | 1 | 1 pulls the data line low |
| addrPinA | input | 2 | First strap pin state (00 low, 01 high, 1x floating) |
| addrPinB | input | 2 | Second strap pin state, same encoding |
| tempIn | input | 16 | Latest conversion result |
| alertPending | input | 1 | Alert block reports an active alert |
| alertStatus | input | 1 | Status bit returned in the alert response |
| cfgOut | output | 8 | Configuration register |
| lowLimOut | output | 16 | Low limit register |
| highLimOut | output | 16 | High limit register |
| hsMode | output | 1 | High-speed signalling announced since last STOP |
| rdStb | output | 1 | One-cycle pulse at the end of a register read |
| araWon | output | 1 | One-cycle pulse when alert arbitration is won |

## Verification
The assertions check several rules on every cycle:
- the data line is never newly pulled while the clock is high;
- `hsMode` is low after any STOP;
- the latched address moves only on a latch event;
- a general-call reset restores the defaults;
- a write aimed at the temperature pointer disturbs no register;
- `araWon` only appears with interrupt mode set.

Only the bench scenarios can show the rest. These are the address table across all nine strap combinations and the byte order of reads. They also cover the sticky pointer, the first-byte-only configuration write, losing arbitration to another target, and the rule that strobes come only from reads that reach the low byte.

// File: rtl/sens_i2c_pkg.sv
package sens_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {BUS_IDLE, BUS_RX, BUS_ACK, BUS_TX, BUS_MACK} busState_t;
  typedef enum logic [1:0] {XF_WRITE, XF_READ, XF_GCALL, XF_ARA} xfer_t;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic              startSeen;
    logic              ptrWr;
    logic              dataWr;
    logic              dataHi;
    logic              pinLatch;
    logic              regReset;
    logic [BYTE_W-1:0] dataByte;
  } ctlStb_t;
endpackage

// File: rtl/sens_i2c_regs.sv
module sens_i2c_regs
  import sens_i2c_pkg::*;
#(
  parameter logic [3:0]        ADDR_HI  = 4'b1001,
  parameter bit                DUAL_PIN = 1'b1,
  parameter int                INT_BIT  = 1,
  parameter logic [BYTE_W-1:0] CFG_DEF  = 8'h00,
  parameter logic [DATA_W-1:0] LOW_DEF  = 16'h4B00,
  parameter logic [DATA_W-1:0] HIGH_DEF = 16'h5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [1:0]        addrPinA,
  input  logic [1:0]        addrPinB,
  input  logic [DATA_W-1:0] tempIn,
  output logic [ADDR_W-1:0] myAddr,
  output logic [DATA_W-1:0] rdWord,
  output logic [BYTE_W-1:0] cfgReg,
  output logic [DATA_W-1:0] lowLim,
  output logic [DATA_W-1:0] highLim,
  output logic              intMode
);
  localparam int LOW_BITS = ADDR_W - 4;

  logic [LOW_BITS-1:0] pinCode;
  logic                latchArm;
  logic                doLatch;
  logic [1:0]          ptr;

  // pin state: 00 low, 01 high, 1x floating
  generate
    if (DUAL_PIN) begin : g_dual
      always_comb begin
        if (addrPinB[1]) pinCode = (addrPinA == 2'b01) ? 3'b111 : 3'b011;
        else begin
          pinCode[2] = addrPinB[0];
          pinCode[1:0] = addrPinA[1] ? 2'b01 : (addrPinA[0] ? 2'b10 : 2'b00);
        end
      end
    end else begin : g_single
      always_comb begin
        pinCode = '0;
        pinCode[1:0] = addrPinA[1] ? 2'b01 : (addrPinA[0] ? 2'b10 : 2'b00);
      end
    end
  endgenerate

  assign doLatch = (latchArm & stb.startSeen) | stb.pinLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchArm <= 1'b1;
      myAddr   <= {ADDR_HI, {LOW_BITS{1'b0}}};
    end else if (doLatch) begin
      latchArm <= 1'b0;
      myAddr   <= {ADDR_HI, pinCode};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= 2'd0;
      cfgReg  <= CFG_DEF;
      lowLim  <= LOW_DEF;
      highLim <= HIGH_DEF;
    end else if (stb.regReset) begin
      ptr     <= 2'd0;
      cfgReg  <= CFG_DEF;
      lowLim  <= LOW_DEF;
      highLim <= HIGH_DEF;
    end else if (stb.ptrWr) begin
      ptr <= stb.dataByte[1:0];
    end else if (stb.dataWr) begin
      case (ptr)
        2'd1: if (stb.dataHi) cfgReg <= stb.dataByte;
        2'd2: if (stb.dataHi) lowLim[DATA_W-1:BYTE_W] <= stb.dataByte;
              else lowLim[BYTE_W-1:0] <= stb.dataByte;
        2'd3: if (stb.dataHi) highLim[DATA_W-1:BYTE_W] <= stb.dataByte;
              else highLim[BYTE_W-1:0] <= stb.dataByte;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ptr)
      2'd0:    rdWord = tempIn;
      2'd1:    rdWord = {cfgReg, {BYTE_W{1'b0}}};
      2'd2:    rdWord = lowLim;
      default: rdWord = highLim;
    endcase
  end

  assign intMode = cfgReg[INT_BIT];

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(doLatch) |-> $stable(myAddr)) else $error("address moved"); // R2

  AST_GC_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.regReset) |-> (ptr == 2'd0 && cfgReg == CFG_DEF &&
                             lowLim == LOW_DEF && highLim == HIGH_DEF)) else $error("reset cmd"); // R7

  AST_TEMP_RO: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.dataWr && ptr == 2'd0) |-> (cfgReg == $past(cfgReg) &&
      lowLim == $past(lowLim) && highLim == $past(highLim))) else $error("temp write"); // R5
endmodule

// File: rtl/sens_i2c_ctrl.sv
module sens_i2c_ctrl
  import sens_i2c_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100,
  parameter logic [BYTE_W-1:0] GC_LATCH = 8'h04,
  parameter logic [BYTE_W-1:0] GC_RESET = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] myAddr,
  input  logic [DATA_W-1:0] rdWord,
  input  logic              intMode,
  input  logic              alertPending,
  input  logic              alertStatus,
  output logic              sdaOe,
  output logic              hsMode,
  output logic              rdStb,
  output logic              araWon,
  output ctlStb_t           stb
);
  busState_t         state;
  xfer_t             xfer, nxtXfer;
  logic              sclQ, sdaQ;
  logic              startDet, stopDet, sclRise, sclFall;
  logic [2:0]        bitCnt;
  logic [2:0]        byteIdx;
  logic              rxFull, ackToTx, txLow, mAck;
  logic [BYTE_W-1:0] shiftIn, txShift, firstTx, nextTx;
  logic [DATA_W-1:0] txWord;
  logic              doAck, goTx, hsHit, byteEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign startDet = sclQ & sclIn & sdaQ & ~sdaIn;
  assign stopDet  = sclQ & sclIn & ~sdaQ & sdaIn;
  assign sclRise  = ~sclQ & sclIn;
  assign sclFall  = sclQ & ~sclIn;
  assign byteEnd  = (state == BUS_RX) && sclFall && rxFull;

  // decision on a completed received byte
  always_comb begin
    doAck = 1'b0; goTx = 1'b0; hsHit = 1'b0; nxtXfer = xfer;
    if (byteIdx == 3'd0) begin
      if (shiftIn[BYTE_W-1:1] == myAddr) begin
        doAck = 1'b1; goTx = shiftIn[0];
        nxtXfer = shiftIn[0] ? XF_READ : XF_WRITE;
      end else if (shiftIn == 8'h00) begin
        doAck = 1'b1; nxtXfer = XF_GCALL;
      end else if (shiftIn == {ARA_ADDR, 1'b1}) begin
        doAck = alertPending & intMode; goTx = 1'b1; nxtXfer = XF_ARA;
      end else if (shiftIn[7:3] == 5'b00001) begin
        hsHit = 1'b1;
      end
    end else begin
      doAck = 1'b1;
    end
  end

  always_comb begin
    stb = '0;
    stb.startSeen = startDet;
    stb.dataByte  = shiftIn;
    if (byteEnd && byteIdx != 3'd0) begin
      if (xfer == XF_WRITE) begin
        stb.ptrWr  = (byteIdx == 3'd1);
        stb.dataWr = (byteIdx == 3'd2) || (byteIdx == 3'd3);
        stb.dataHi = (byteIdx == 3'd2);
      end else if (xfer == XF_GCALL && byteIdx == 3'd1) begin
        stb.pinLatch = (shiftIn == GC_LATCH) || (shiftIn == GC_RESET);
        stb.regReset = (shiftIn == GC_RESET);
      end
    end
  end

  assign firstTx = (xfer == XF_ARA) ? {myAddr, alertStatus} : rdWord[DATA_W-1:BYTE_W];
  assign nextTx  = txLow ? txWord[DATA_W-1:BYTE_W] : txWord[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= BUS_IDLE; xfer <= XF_WRITE;
      bitCnt <= '0; byteIdx <= '0; rxFull <= 1'b0;
      ackToTx <= 1'b0; txLow <= 1'b0; mAck <= 1'b0;
      shiftIn <= '0; txShift <= '0; txWord <= '0;
      sdaOe <= 1'b0; hsMode <= 1'b0; rdStb <= 1'b0; araWon <= 1'b0;
    end else begin
      rdStb  <= 1'b0;
      araWon <= 1'b0;
      if (startDet) begin
        state <= BUS_RX; bitCnt <= '0; byteIdx <= '0; rxFull <= 1'b0; sdaOe <= 1'b0;
      end else if (stopDet) begin
        state <= BUS_IDLE; sdaOe <= 1'b0; hsMode <= 1'b0;
      end else begin
        case (state)
          BUS_RX: begin
            if (sclRise) begin
              shiftIn <= {shiftIn[BYTE_W-2:0], sdaIn};
              bitCnt  <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) rxFull <= 1'b1;
            end else if (byteEnd) begin
              rxFull <= 1'b0;
              if (hsHit) hsMode <= 1'b1;
              if (doAck) begin
                state <= BUS_ACK; sdaOe <= 1'b1;
                xfer <= nxtXfer; ackToTx <= goTx;
                if (byteIdx != 3'd4) byteIdx <= byteIdx + 3'd1;
              end else begin
                state <= BUS_IDLE;
              end
            end
          end
          BUS_ACK: if (sclFall) begin
            bitCnt <= '0;
            if (ackToTx) begin
              state <= BUS_TX; txShift <= firstTx; sdaOe <= ~firstTx[BYTE_W-1];
              txWord <= rdWord; txLow <= 1'b0;
            end else begin
              state <= BUS_RX; sdaOe <= 1'b0;
            end
          end
          BUS_TX: begin
            if (sclRise && xfer == XF_ARA && !sdaOe && !sdaIn) begin
              state <= BUS_IDLE;
            end else if (sclFall) begin
              if (bitCnt == 3'd7) begin
                state <= BUS_MACK; sdaOe <= 1'b0;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                sdaOe   <= ~txShift[BYTE_W-2];
                bitCnt  <= bitCnt + 3'd1;
              end
            end
          end
          BUS_MACK: begin
            if (sclRise) begin
              mAck <= ~sdaIn;
              if (xfer == XF_READ && txLow) rdStb <= 1'b1;
              if (xfer == XF_ARA) araWon <= 1'b1;
            end else if (sclFall) begin
              if (mAck && xfer == XF_READ) begin
                state <= BUS_TX; txShift <= nextTx; sdaOe <= ~nextTx[BYTE_W-1];
                txLow <= ~txLow; bitCnt <= '0;
              end else begin
                state <= BUS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_NO_FALSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && sclQ) |-> !$rose(sdaOe)) else $error("pull while clock high"); // R11

  AST_HS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !hsMode) else $error("hs after stop"); // R9

  AST_ARA_NEEDS_INT: assert property (@(posedge clk) disable iff (!rstN)
    araWon |-> intMode) else $error("alert response without interrupt mode"); // R8

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && araWon)) else $error("both strobes"); // R10
endmodule

// File: rtl/sens_i2c_target.sv
module sens_i2c_target
  import sens_i2c_pkg::*;
#(
  parameter logic [3:0]        ADDR_HI  = 4'b1001,
  parameter bit                DUAL_PIN = 1'b1,
  parameter int                INT_BIT  = 1,
  parameter logic [BYTE_W-1:0] CFG_DEF  = 8'h00,
  parameter logic [DATA_W-1:0] LOW_DEF  = 16'h4B00,
  parameter logic [DATA_W-1:0] HIGH_DEF = 16'h5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [1:0]        addrPinA,
  input  logic [1:0]        addrPinB,
  input  logic [DATA_W-1:0] tempIn,
  input  logic              alertPending,
  input  logic              alertStatus,
  output logic [BYTE_W-1:0] cfgOut,
  output logic [DATA_W-1:0] lowLimOut,
  output logic [DATA_W-1:0] highLimOut,
  output logic              hsMode,
  output logic              rdStb,
  output logic              araWon
);
  ctlStb_t           stb;
  logic [ADDR_W-1:0] myAddr;
  logic [DATA_W-1:0] rdWord;
  logic              intMode;

  sens_i2c_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .myAddr(myAddr), .rdWord(rdWord), .intMode(intMode),
    .alertPending(alertPending), .alertStatus(alertStatus),
    .sdaOe(sdaOe), .hsMode(hsMode), .rdStb(rdStb), .araWon(araWon), .stb(stb)
  );

  sens_i2c_regs #(
    .ADDR_HI(ADDR_HI), .DUAL_PIN(DUAL_PIN), .INT_BIT(INT_BIT),
    .CFG_DEF(CFG_DEF), .LOW_DEF(LOW_DEF), .HIGH_DEF(HIGH_DEF)
  ) regs_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addrPinA(addrPinA), .addrPinB(addrPinB),
    .tempIn(tempIn), .myAddr(myAddr), .rdWord(rdWord), .cfgReg(cfgOut),
    .lowLim(lowLimOut), .highLim(highLimOut), .intMode(intMode)
  );
endmodule

// File: tb/sens_i2c_target_tb_top.sv
module sens_i2c_target_tb_top;
  localparam int HALF = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, extPull = 1'b0;
  logic sdaOe, sdaBus;
  logic [1:0] pinA = 2'b01, pinB = 2'b01;
  logic [15:0] tempIn = 16'h1900;
  logic alertPending = 1'b0, alertStatus = 1'b0;
  logic [7:0] cfgOut;
  logic [15:0] lowLimOut, highLimOut;
  logic hsMode, rdStb, araWon;

  assign sdaBus = sdaM & ~sdaOe & ~extPull;

  sens_i2c_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .addrPinA(pinA), .addrPinB(pinB), .tempIn(tempIn),
    .alertPending(alertPending), .alertStatus(alertStatus),
    .cfgOut(cfgOut), .lowLimOut(lowLimOut), .highLimOut(highLimOut),
    .hsMode(hsMode), .rdStb(rdStb), .araWon(araWon)
  );

  int checks = 0, errors = 0, rdCnt = 0, araCnt = 0;
  logic [6:0] devAddr;

  always @(posedge clk) begin
    if (rdStb) rdCnt++;
    if (araWon) araCnt++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pinEnc(int s); // 0 low, 1 high, 2 float
    return (s == 0) ? 2'b00 : ((s == 1) ? 2'b01 : 2'b10);
  endfunction

  function automatic logic [6:0] expAddr(int b, int a);
    int lowBits;
    if (b == 2) lowBits = (a == 1) ? 7 : 3;
    else lowBits = 4 * b + ((a == 0) ? 0 : ((a == 2) ? 1 : 2));
    return 7'(72 + lowBits);
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(2); sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b0; waitClk(HALF); sclM = 1'b0; waitClk(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(2); sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b1; waitClk(HALF);
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b; waitClk(HALF); sclM = 1'b1; waitClk(HALF / 2);
    s = sdaBus; waitClk(HALF / 2); sclM = 1'b0; waitClk(2);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic ackIt, input logic [7:0] pullMask, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      extPull = pullMask[i];
      clockBit(1'b1, s);
      v = {v[6:0], s};
    end
    extPull = 1'b0;
    clockBit(~ackIt, s);
  endtask

  task automatic readReg(output logic [15:0] w, output logic ack);
    logic [7:0] hi, lo;
    busStart(); sendByte({devAddr, 1'b1}, ack);
    recvByte(1'b1, 8'h00, hi); recvByte(1'b0, 8'h00, lo);
    busStop(); w = {hi, lo};
  endtask

  // pointer then nData bytes; returns 1 only if every byte was acknowledged
  task automatic writeRegs(input logic [7:0] ptr, input int nData, input logic [23:0] data,
                           output logic allAck);
    logic a;
    busStart(); sendByte({devAddr, 1'b0}, a); allAck = a;
    sendByte(ptr, a); allAck &= a;
    for (int i = 0; i < nData; i++) begin
      sendByte(data[23 - 8 * i -: 8], a); allAck &= a;
    end
    busStop();
  endtask

  task automatic genCall(input logic [7:0] cmd, output logic allAck);
    logic a;
    busStart(); sendByte(8'h00, a); allAck = a;
    sendByte(cmd, a); allAck &= a; busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack, allAck;
    logic [15:0] w;
    logic [7:0] v;
    int rd0, ar0;

    waitClk(5); rstN = 1'b1; waitClk(3);
    check("R7 reset cfg", cfgOut, 8'h00);
    check("R7 reset low limit", lowLimOut, 16'h4B00);
    check("R7 reset high limit", highLimOut, 16'h5000);
    check("R11 reset sdaOe", sdaOe, 1'b0);
    check("R9 reset hsMode", hsMode, 1'b0);

    // first START after reset samples pins (high, high) -> 1001110
    devAddr = expAddr(1, 1);
    writeRegs(8'h03, 2, 24'h123400, allAck);
    check("R2 first-start latch and R5 acks", allAck, 1'b1);
    check("R5 high limit written", highLimOut, 16'h1234);
    check("R11 released after stop", sdaOe, 1'b0);

    rd0 = rdCnt;
    readReg(w, ack);
    check("R4 read high limit", w, 16'h1234);
    check("R10 one read strobe", rdCnt - rd0, 1);
    readReg(w, ack);
    check("R4 sticky pointer", w, 16'h1234);

    writeRegs(8'h02, 0, 24'h0, allAck);
    check("R5 pointer-only ack", allAck, 1'b1);
    check("R5 pointer-only no change", lowLimOut, 16'h4B00);
    readReg(w, ack);
    check("R3 pointer 10 selects low limit", w, 16'h4B00);

    writeRegs(8'hFD, 2, 24'hA53C00, allAck); // low bits 01
    check("R6 cfg first byte only", cfgOut, 8'hA5);
    readReg(w, ack);
    check("R6 cfg read back", w, 16'hA500);

    writeRegs(8'h00, 2, 24'h778800, allAck);
    check("R5 temperature write acked", allAck, 1'b1);
    check("R5 temperature write ignored", {cfgOut, lowLimOut, highLimOut}, {8'hA5, 16'h4B00, 16'h1234});
    readReg(w, ack);
    check("R4 temperature from input", w, 16'h1900);
    tempIn = 16'hE700;
    readReg(w, ack);
    check("R4 temperature follows input", w, 16'hE700);

    rd0 = rdCnt;
    busStart(); sendByte({devAddr, 1'b1}, ack); recvByte(1'b0, 8'h00, v); busStop();
    check("R10 NACK after high byte ends read", v, 8'hE7);
    check("R10 no strobe for short read", rdCnt - rd0, 0);

    // pins move without a latch command
    pinA = 2'b00; pinB = 2'b00;
    busStart(); sendByte({devAddr, 1'b0}, ack); busStop();
    check("R2 address held after pin change", ack, 1'b1);
    busStart(); sendByte({expAddr(0, 0), 1'b0}, ack);
    check("R12 unmatched address nack", ack, 1'b0);
    waitClk(HALF);
    check("R12 line released", sdaOe, 1'b0);
    busStop();

    // sweep all strap combinations through general-call latch
    for (int b = 0; b < 3; b++) begin
      for (int a = 0; a < 3; a++) begin
        pinB = pinEnc(b); pinA = pinEnc(a);
        genCall(8'h04, allAck);
        check("R7 general call 04 acked", allAck, 1'b1);
        busStart(); sendByte({expAddr(b, a), 1'b0}, ack); busStop();
        check("R1 strap address acked", ack, 1'b1);
        busStart(); sendByte({expAddr(b, a) ^ 7'h04, 1'b0}, ack); busStop();
        check("R1 neighbour address nack", ack, 1'b0);
      end
    end
    devAddr = expAddr(2, 2);
    check("R7 latch keeps registers", cfgOut, 8'hA5);

    busStart(); sendByte(8'h0B, ack);
    check("R9 high-speed code nack", ack, 1'b0);
    check("R9 hsMode set", hsMode, 1'b1);
    busStart(); sendByte({devAddr, 1'b0}, ack);
    check("R9 hsMode held over repeated START", hsMode, 1'b1);
    busStop();
    check("R9 hsMode cleared by STOP", hsMode, 1'b0);

    alertPending = 1'b1; alertStatus = 1'b1;
    busStart(); sendByte(8'h19, ack); busStop();
    check("R8 alert response refused without interrupt mode", ack, 1'b0);
    writeRegs(8'h01, 1, 24'h020000, allAck);
    alertPending = 1'b0;
    busStart(); sendByte(8'h19, ack); busStop();
    check("R8 alert response refused without pending alert", ack, 1'b0);
    alertPending = 1'b1;
    ar0 = araCnt;
    busStart(); sendByte(8'h19, ack);
    check("R8 alert response acked", ack, 1'b1);
    recvByte(1'b0, 8'h00, v); busStop();
    check("R8 alert response byte", v, {devAddr, 1'b1});
    check("R8 arbitration won strobe", araCnt - ar0, 1);
    ar0 = araCnt;
    busStart(); sendByte(8'h19, ack);
    recvByte(1'b0, 8'h80, v); busStop();
    check("R8 lost arbitration releases line", v, 8'h7F);
    check("R8 no strobe when lost", araCnt - ar0, 0);
    check("R11 released after lost arbitration", sdaOe, 1'b0);
    alertPending = 1'b0;

    genCall(8'h06, allAck);
    check("R7 general call 06 acked", allAck, 1'b1);
    check("R7 reset command restores", {cfgOut, lowLimOut, highLimOut}, {8'h00, 16'h4B00, 16'h5000});
    readReg(w, ack);
    check("R3 pointer back to temperature", w, 16'hE700);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule